// File: doc/BRIEF.md
# Cartridge Window Bank Mapper

This block sits between a 16-bit host bus and the memories behind an 8 KB cartridge window. Each host access carries a 12-bit word offset inside the window. The block combines that offset with a 2-bit current bank and with the memory port selected last, and forms a byte address. It also picks one backing memory: cartridge RAM, cartridge flash, or nothing. A read returns the selected memory's 16-bit word. The even byte sits in bits 15:8 and the odd byte in bits 7:0.

Writes into the window do one of two things. Some writes switch banks and store nothing. A write switches banks when the bank-hold control is clear, or when it hits the mapper location while mapper mode is on. Every other write may store bytes into RAM through separate high-byte and low-byte strobes. A store needs either the global write enable or an offset inside the mapper-mode RAM sub-range, which does not depend on the global write enable. The flash is read-only through this window. The memory arrays themselves live outside the block.

Top module: `cartwin_mapper`

## Requirements
- R1: `mem_addr` equals port index × 0x8000 + bank × 0x2000 + word offset × 2. The port index occupies bits 18:15, the bank bits 14:13, the offset bits 12:1, and bit 0 is 0.
- R2: While `bank_hold` is 0, every valid write sets the bank to `word_off[1:0]` from the next clock on. Such a write raises no RAM strobe.
- R3: While `bank_hold` is 1 and `mapper_mode` is 1, a valid write to offset 0x7FF with `be_hi` set loads the bank from `wdata[9:8]`. It raises no strobe. Without `be_hi`, or without `mapper_mode`, that write leaves the bank alone.
- R4: A store into RAM is permitted only when `wr_en` is 1, or when `mapper_mode` is 1 and the offset lies in 0x600 to 0x7FE inclusive.
- R5: Ports 0 and 1 map to RAM when `ram_sub` is 1 and to flash otherwise. Ports 2 to 15 map to flash. A write to a flash target raises no strobe and no select.
- R6: Ports 32 and 33 always map to RAM, with port index 0 and 1 respectively.
- R7: Every other port reads 0, raises no select and ignores writes.
- R8: `ram_we_hi` follows `be_hi` and `ram_we_lo` follows `be_lo` on a permitted RAM store. `mem_wdata` carries `wdata`.
- R9: A read returns `ram_rdata` or `flash_rdata` from the selected memory. It asserts exactly that memory's select.
- R10: The bank is 0 after reset. Reads and stores leave the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| word_off | input | 12 | Word offset inside the window |
| wdata | input | 16 | Host write data |
| be_hi | input | 1 | High-byte (bits 15:8) enable |
| be_lo | input | 1 | Low-byte (bits 7:0) enable |
| sel_port | input | 6 | Memory port selected last |
| bank_hold | input | 1 | 0 = writes select the bank from the offset |
| mapper_mode | input | 1 | Mapper-register mode |
| wr_en | input | 1 | Global RAM write enable |
| ram_sub | input | 1 | Ports 0-1 use RAM instead of flash |
| ram_rdata | input | 16 | RAM word at `mem_addr` |
| flash_rdata | input | 16 | Flash word at `mem_addr` |
| rd_data | output | 16 | Read result |
| mem_addr | output | 19 | Byte address of the even byte |
| ram_sel | output | 1 | RAM accessed |
| flash_sel | output | 1 | Flash read |
| ram_we_hi | output | 1 | RAM even-byte write strobe |
| ram_we_lo | output | 1 | RAM odd-byte write strobe |
| mem_wdata | output | 16 | Write data to RAM |

## Verification
The only state in the block is the bank register. A wrong bank shows up in bits 14:13 of `mem_addr` on the very next access. It also changes `rd_data` on that access, because the bench memory model returns address-dependent words. The bench therefore reads after every bank change and after every write sweep, so a bank that moved when it should not have is caught within one access. Decode faults are combinational and appear in the same cycle as the access: a wrong target, a wrong port index or a stray strobe.

// File: rtl/cwm_pkg.sv
// Shared types for the cartridge window mapper.
// Assumes: one target per access; the target set is closed.
package cwm_pkg;
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_RAM   = 2'd1,
        TGT_FLASH = 2'd2
    } tgt_e;
endpackage

// File: rtl/cwm_port_decode.sv
// Maps the last selected port to a backing memory and a port index.
// Assumes: port numbers below SUB_PORTS may swap flash for RAM;
// the RAM mirror starts at RAM_BASE and is rebased to index 0.
module cwm_port_decode
    import cwm_pkg::*;
#(
    parameter int PORT_W      = 6,
    parameter int IDX_W       = 4,
    parameter int SUB_PORTS   = 2,
    parameter int FLASH_PORTS = 16,
    parameter int RAM_BASE    = 32,
    parameter int RAM_PORTS   = 2
) (
    input  logic [PORT_W-1:0] port,
    input  logic              ram_sub,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx
);
    // Classify the port by range and derive its index.
    always_comb begin
        int unsigned p;
        p   = 32'(port);
        tgt = TGT_NONE;
        idx = '0;
        if (p < 32'(SUB_PORTS)) begin
            tgt = ram_sub ? TGT_RAM : TGT_FLASH;
            idx = IDX_W'(p);
        end else if (p < 32'(FLASH_PORTS)) begin
            tgt = TGT_FLASH;
            idx = IDX_W'(p);
        end else if (p >= 32'(RAM_BASE) && p < 32'(RAM_BASE + RAM_PORTS)) begin
            tgt = TGT_RAM;
            idx = IDX_W'(p - 32'(RAM_BASE));
        end
    end
endmodule

// File: rtl/cwm_bank_ctl.sv
// Holds the current bank and decides which writes switch it.
// Assumes: wr_stb is a qualified host write; a switching write
// never stores, which the store gate learns through switch_hit.
module cwm_bank_ctl #(
    parameter int OFF_W   = 12,
    parameter int BANK_W  = 2,
    parameter int MAP_OFF = 'h7FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              bank_hold,
    input  logic              mapper_mode,
    input  logic              be_hi,
    input  logic [OFF_W-1:0]  word_off,
    input  logic [BANK_W-1:0] map_bits,
    output logic [BANK_W-1:0] bank,
    output logic              switch_hit
);
    logic addr_sw;
    logic map_sw;

    // Classify the current write as an address switch or a mapper load.
    always_comb begin
        addr_sw    = wr_stb && !bank_hold;
        map_sw     = wr_stb && bank_hold && mapper_mode && be_hi
                     && (word_off == OFF_W'(MAP_OFF));
        switch_hit = addr_sw || map_sw;
    end

    // Bank register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       bank <= '0;
        else if (addr_sw) bank <= word_off[BANK_W-1:0];
        else if (map_sw)  bank <= map_bits;
    end

    p_addr_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !bank_hold) |=> (bank == $past(word_off[BANK_W-1:0])));

    p_mapper_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && bank_hold && mapper_mode && be_hi && word_off == OFF_W'(MAP_OFF))
        |=> (bank == $past(map_bits)));

    p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb) |=> $stable(bank));
endmodule

// File: rtl/cwm_store_gate.sv
// Grants RAM byte strobes for writes that are allowed to store.
// Assumes: switch_hit already covers every bank-switching write.
module cwm_store_gate
    import cwm_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int SUB_LO = 'h600,
    parameter int SUB_HI = 'h7FE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             switch_hit,
    input  logic             wr_en,
    input  logic             mapper_mode,
    input  logic [OFF_W-1:0] word_off,
    input  tgt_e             tgt,
    input  logic             be_hi,
    input  logic             be_lo,
    output logic             we_hi,
    output logic             we_lo
);
    logic in_sub;
    logic store_ok;

    // Permission: global enable, or mapper-mode RAM sub-range.
    always_comb begin
        in_sub   = (word_off >= OFF_W'(SUB_LO)) && (word_off <= OFF_W'(SUB_HI));
        store_ok = wr_stb && !switch_hit && (tgt == TGT_RAM)
                   && (wr_en || (mapper_mode && in_sub));
        we_hi    = store_ok && be_hi;
        we_lo    = store_ok && be_lo;
    end

    p_store_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi || we_lo) |-> (wr_en || mapper_mode));
endmodule

// File: rtl/cartwin_mapper.sv
// Top of the cartridge window mapper: decodes host accesses into a
// memory select, a byte address, byte strobes and read data.
// Assumes: memories answer combinationally with the word whose even
// byte is at mem_addr, even byte in the high half.
module cartwin_mapper
    import cwm_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int BANK_W = 2,
    parameter int PORT_W = 6,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                acc_valid,
    input  logic                                acc_write,
    input  logic [OFF_W-1:0]                    word_off,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                be_hi,
    input  logic                                be_lo,
    input  logic [PORT_W-1:0]                   sel_port,
    input  logic                                bank_hold,
    input  logic                                mapper_mode,
    input  logic                                wr_en,
    input  logic                                ram_sub,
    input  logic [DATA_W-1:0]                   ram_rdata,
    input  logic [DATA_W-1:0]                   flash_rdata,
    output logic [DATA_W-1:0]                   rd_data,
    output logic [IDX_W+BANK_W+OFF_W:0]         mem_addr,
    output logic                                ram_sel,
    output logic                                flash_sel,
    output logic                                ram_we_hi,
    output logic                                ram_we_lo,
    output logic [DATA_W-1:0]                   mem_wdata
);
    localparam int MAP_LSB = DATA_W / 2;

    tgt_e              tgt;
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] bank;
    logic              switch_hit;
    logic              wr_stb;
    logic              rd_stb;

    // Qualify the host strobes.
    always_comb begin
        wr_stb = acc_valid && acc_write;
        rd_stb = acc_valid && !acc_write;
    end

    cwm_port_decode #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_dec (
        .port    (sel_port),
        .ram_sub (ram_sub),
        .tgt     (tgt),
        .idx     (idx)
    );

    cwm_bank_ctl #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .bank_hold   (bank_hold),
        .mapper_mode (mapper_mode),
        .be_hi       (be_hi),
        .word_off    (word_off),
        .map_bits    (wdata[MAP_LSB+BANK_W-1:MAP_LSB]),
        .bank        (bank),
        .switch_hit  (switch_hit)
    );

    cwm_store_gate #(.OFF_W(OFF_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .switch_hit  (switch_hit),
        .wr_en       (wr_en),
        .mapper_mode (mapper_mode),
        .word_off    (word_off),
        .tgt         (tgt),
        .be_hi       (be_hi),
        .be_lo       (be_lo),
        .we_hi       (ram_we_hi),
        .we_lo       (ram_we_lo)
    );

    // Byte address: port index, bank and word offset packed by weight.
    always_comb mem_addr = {idx, bank, word_off, 1'b0};

    // Read data mux and memory selects.
    always_comb begin
        rd_data   = '0;
        flash_sel = rd_stb && (tgt == TGT_FLASH);
        ram_sel   = (rd_stb && (tgt == TGT_RAM)) || ram_we_hi || ram_we_lo;
        if (rd_stb) begin
            case (tgt)
                TGT_RAM:   rd_data = ram_rdata;
                TGT_FLASH: rd_data = flash_rdata;
                default:   rd_data = '0;
            endcase
        end
        mem_wdata = wdata;
    end

    p_sel_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, flash_sel}));

    p_switch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        switch_hit |-> !(ram_we_hi || ram_we_lo));

    p_flash_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tgt == TGT_FLASH) |-> !(ram_we_hi || ram_we_lo || flash_sel));

    p_none_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && tgt == TGT_NONE) |-> (rd_data == '0 && !ram_sel && !ram_we_hi && !ram_we_lo));
endmodule

// File: tb/cartwin_mapper_test.sv
module cartwin_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [11:0] word_off = '0;
    logic [15:0] wdata = '0;
    logic        be_hi = 1'b0, be_lo = 1'b0;
    logic [5:0]  sel_port = '0;
    logic        bank_hold = 1'b1, mapper_mode = 1'b0, wr_en = 1'b0, ram_sub = 1'b0;
    logic [15:0] ram_rdata, flash_rdata, rd_data, mem_wdata;
    logic [18:0] mem_addr;
    logic        ram_sel, flash_sel, ram_we_hi, ram_we_lo;

    int n_cmp = 0;
    int n_bad = 0;
    int bank_m = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] bval(input logic [18:0] a, input logic [7:0] salt);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ salt;
    endfunction

    // Memory models: even byte high, odd byte low.
    assign ram_rdata   = {bval(mem_addr, 8'h11), bval(mem_addr | 19'd1, 8'h11)};
    assign flash_rdata = {bval(mem_addr, 8'hC3), bval(mem_addr | 19'd1, 8'hC3)};

    cartwin_mapper uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .word_off(word_off), .wdata(wdata), .be_hi(be_hi), .be_lo(be_lo),
        .sel_port(sel_port), .bank_hold(bank_hold), .mapper_mode(mapper_mode),
        .wr_en(wr_en), .ram_sub(ram_sub), .ram_rdata(ram_rdata),
        .flash_rdata(flash_rdata), .rd_data(rd_data), .mem_addr(mem_addr),
        .ram_sel(ram_sel), .flash_sel(flash_sel), .ram_we_hi(ram_we_hi),
        .ram_we_lo(ram_we_lo), .mem_wdata(mem_wdata)
    );

    task automatic check(input int got, input int exp, input string tag);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // 0 none, 1 RAM, 2 flash
    function automatic int tgt_of(input int p, input int rs);
        if (p < 2) return rs ? 1 : 2;
        if (p < 16) return 2;
        if (p == 32 || p == 33) return 1;
        return 0;
    endfunction

    function automatic int idx_of(input int p);
        return (p >= 32) ? p - 32 : p;
    endfunction

    function automatic logic [18:0] exp_addr(input int p, input int b, input int off);
        return 19'((idx_of(p) << 15) | (b << 13) | (off << 1));
    endfunction

    task automatic do_read(input int p, input int rs, input int off, input string tag);
        logic [18:0] ea;
        int t;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; sel_port = 6'(p); ram_sub = rs[0];
        word_off = 12'(off); be_hi = 1'b1; be_lo = 1'b1;
        #1;
        t  = tgt_of(p, rs);
        ea = exp_addr(p, bank_m, off);
        if (t != 0) check(int'(mem_addr), int'(ea), {tag, " R1 addr"});
        if (t == 1) check(int'(rd_data), int'({bval(ea, 8'h11), bval(ea | 19'd1, 8'h11)}), {tag, " R9 ram data"});
        else if (t == 2) check(int'(rd_data), int'({bval(ea, 8'hC3), bval(ea | 19'd1, 8'hC3)}), {tag, " R9 flash data"});
        else check(int'(rd_data), 0, {tag, " R7 none data"});
        check(int'({ram_sel, flash_sel}), (t == 1) ? 2 : (t == 2) ? 1 : 0, {tag, " R5 R6 R7 selects"});
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic do_write(input int p, input int off, input logic [15:0] d,
                            input logic bh, input logic bl, input int exp_we, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; sel_port = 6'(p);
        word_off = 12'(off); wdata = d; be_hi = bh; be_lo = bl;
        #1;
        check(int'({ram_we_hi, ram_we_lo}), exp_we, {tag, " strobes"});
        check(int'(flash_sel), 0, {tag, " R5 no flash select on write"});
        if (exp_we != 0) begin
            check(int'(mem_addr), int'(exp_addr(p, bank_m, off)), {tag, " R1 store addr"});
            check(int'(mem_wdata), int'(d), {tag, " R8 wdata"});
        end
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int offs[5];
        offs = '{'h5FF, 'h600, 'h7FE, 'h7FF, 'h800};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: bank is 0 after reset
        do_read(2, 0, 0, "R10 reset bank");

        // R2 and read sweep over every bank, port, ram_sub and offset
        for (int b = 0; b < 4; b++) begin
            bank_hold = 1'b0; wr_en = 1'b1;
            ram_sub = 1'b1;
            do_write(0, 'hA4 | b, 16'hFFFF, 1'b1, 1'b1, 0, "R2 switch no store");
            bank_m = b;
            bank_hold = 1'b1; wr_en = 1'b0;
            for (int p = 0; p < 64; p++)
                for (int rs = 0; rs < 2; rs++) begin
                    do_read(p, rs, 0, "sweep");
                    do_read(p, rs, 'h5A3, "sweep");
                    do_read(p, rs, 'hFFF, "sweep");
                end
        end

        // R3: mapper location
        mapper_mode = 1'b1; ram_sub = 1'b1;
        do_write(0, 'h7FF, 16'h0200, 1'b1, 1'b0, 0, "R3 mapper load");
        bank_m = 2;
        do_read(2, 0, 'h10, "R3 bank from data");
        do_write(0, 'h7FF, 16'h0100, 1'b0, 1'b1, 0, "R3 low byte only");
        do_read(2, 0, 'h10, "R3 bank kept without be_hi");
        mapper_mode = 1'b0;
        do_write(0, 'h7FF, 16'h0100, 1'b1, 1'b1, 0, "R3 mapper off");
        do_read(2, 0, 'h10, "R3 bank kept without mapper");

        // R4 R5 R6 R7 R8: store sweep with bank_hold set
        for (int p = 0; p < 64; p++)
            for (int rs = 0; rs < 2; rs++)
                for (int we = 0; we < 2; we++)
                    for (int mm = 0; mm < 2; mm++)
                        for (int oi = 0; oi < 5; oi++)
                            for (int be = 0; be < 4; be++) begin
                                int off, ok, sw, ewe;
                                off = offs[oi];
                                ram_sub = rs[0]; wr_en = we[0]; mapper_mode = mm[0];
                                sw  = (mm == 1 && off == 'h7FF && be[1]) ? 1 : 0;
                                ok  = (we == 1 || (mm == 1 && off >= 'h600 && off <= 'h7FE)) ? 1 : 0;
                                ewe = (tgt_of(p, rs) == 1 && sw == 0 && ok == 1) ? be : 0;
                                do_write(p, off, 16'h02C5 ^ 16'(p << 10), be[1], be[0], ewe,
                                         "R4 R8 store sweep");
                            end
        wr_en = 1'b0; mapper_mode = 1'b0;
        // R10: stores and reads left bank at 2
        do_read(33, 0, 'h321, "R10 R6 bank after stores");
        do_read(5, 1, 'h321, "R10 bank after stores");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule